// File: doc/BRIEF.md
# Bus Bridge First/Next Error Capture Logger

This block keeps the error history of a bus bridge. An 8-bit vector of error events comes in every cycle. The first time any error fires while the log is empty, every bit set in that cycle goes into a first-error status register. In the same cycle, a snapshot is frozen of the bus address phase and the bus data phase sampled in that cycle. Errors that come later are OR-ed into a separate next-error status register. The snapshot does not move again until software empties the first-error register.

Software reads and writes the four logging registers through a small select/write port. The two status registers clear by write-one-to-clear. The two snapshot registers take plain writes, but only while the first-error register is empty. All logged state is sticky. A cold reset clears it. A warm reset leaves it untouched and blocks both logging and software writes while it is asserted. One output flag tells the rest of the chip that an error is pending.

Top module: `err_capture_logger`

## Requirements
- R1: Cold reset (active low, asynchronous) clears all four registers and deasserts the pending flag.
- R2: When the first-error register is zero and the event vector is nonzero, the first-error register takes the whole event vector of that cycle on the next clock edge.
- R3: While the first-error register is nonzero, each event bit is OR-ed into the next-error register. Errors that land in the first-error register do not also set the next-error register.
- R4: A write to either status register clears each bit written as 1 and leaves bits written as 0 unchanged.
- R5: If an event and a clearing write hit the same status register in the same cycle, the event bit ends up set. If a write empties the first-error register in the same cycle as an event, that event goes to the next-error register.
- R6: At the cycle that fills the first-error register, the address snapshot loads address in bits 39:0, command in 43:40 and address parity in bit 44. Later errors leave it unchanged.
- R7: Address snapshot bit 45 holds the second-phase parity only when the dual-address-cycle input is 1, and holds 0 otherwise. Bits 63:46 read as zero.
- R8: At that same cycle, the data snapshot loads data in bits 31:0, byte enables in 35:32 and data parity in bit 36. Bits 63:37 read as zero.
- R9: Software writes to the snapshot registers take effect only while the first-error register is zero, and only in the defined bits. A first-error capture in the same cycle wins over the write. After the first-error register is cleared, the next error takes a fresh snapshot.
- R10: While warm reset is low, all registers keep their contents, and both events and writes are ignored.
- R11: The pending flag is 1 exactly when the first-error or the next-error register is nonzero.
- R12: The read data shows the register picked by the select input: 0 first-error, 1 next-error, 2 address snapshot, 3 data snapshot. Status registers are zero-extended to 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| cold_rst_n_i | input | 1 | Cold reset, active low, clears all state |
| warm_rst_n_i | input | 1 | Warm reset, active low, freezes state |
| err_evt_i | input | 8 | Error events of this cycle |
| bus_addr_i | input | 40 | Sampled bus address |
| bus_cmd_i | input | 4 | Sampled bus command |
| bus_dac_i | input | 1 | Current address phase is a dual-address cycle |
| bus_apar_i | input | 1 | Parity of address (first half for dual cycle) |
| bus_apar2_i | input | 1 | Parity of second address phase |
| bus_data_i | input | 32 | Sampled bus data |
| bus_be_i | input | 4 | Sampled byte enables |
| bus_dpar_i | input | 1 | Data parity |
| reg_sel_i | input | 2 | Register select for read and write |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 64 | Write data |
| reg_rdata_o | output | 64 | Read data of the selected register |
| err_pending_o | output | 1 | Some status bit is set |

## Verification
Two pairs of actions can land in one clock edge: an error event together with a software write-one-to-clear of the same status register, and a first-error capture together with a software write to a snapshot register. The bench drives both halves of each pair in a single cycle. It then reads the registers back. Each result is judged against the stated winner: the event bit stays set, an event that coincides with emptying the first-error register lands in the next-error register, and the snapshot shows the bus values rather than the written value.

// File: rtl/errlog_pkg.sv
package errlog_pkg;
    typedef enum logic [1:0] {
        SEL_FIRST = 2'd0,
        SEL_NEXT  = 2'd1,
        SEL_ADDR  = 2'd2,
        SEL_DATA  = 2'd3
    } errlog_sel_e;
endpackage

// File: rtl/errlog_status.sv
module errlog_status #(
    parameter int EVT_W = 8
) (
    input  logic             clk_i,
    input  logic             cold_rst_n_i,
    input  logic             warm_rst_n_i,
    input  logic [EVT_W-1:0] evt_i,
    input  logic [EVT_W-1:0] first_clr_i,
    input  logic [EVT_W-1:0] next_clr_i,
    output logic [EVT_W-1:0] first_o,
    output logic [EVT_W-1:0] next_o,
    output logic             new_first_o,
    output logic             frozen_o
);
    typedef struct packed {
        logic [EVT_W-1:0] first;
        logic [EVT_W-1:0] next;
    } status_t;

    status_t st_d, st_q;
    logic [EVT_W-1:0] evt_v, fclr_v, nclr_v;
    logic             first_empty;

    assign evt_v  = warm_rst_n_i ? evt_i       : '0;
    assign fclr_v = warm_rst_n_i ? first_clr_i : '0;
    assign nclr_v = warm_rst_n_i ? next_clr_i  : '0;
    assign first_empty = (st_q.first == '0);

    always_comb begin
        st_d       = st_q;
        st_d.first = st_q.first & ~fclr_v;
        st_d.next  = st_q.next  & ~nclr_v;
        if (first_empty) begin
            st_d.first = evt_v;
        end else begin
            st_d.next = st_d.next | evt_v;
        end
    end

    always_ff @(posedge clk_i or negedge cold_rst_n_i) begin
        if (!cold_rst_n_i) st_q <= '0;
        else               st_q <= st_d;
    end

    assign first_o     = st_q.first;
    assign next_o      = st_q.next;
    assign new_first_o = first_empty && (evt_v != '0);
    assign frozen_o    = !first_empty;

    // R2
    first_capture_chk: assert property (@(posedge clk_i) disable iff (!cold_rst_n_i)
        (first_empty && evt_v != '0) |=> (st_q.first == $past(evt_v)));
    // R3
    next_no_dup_chk: assert property (@(posedge clk_i) disable iff (!cold_rst_n_i)
        (first_empty && evt_v != '0) |=> (st_q.next == ($past(st_q.next) & ~$past(nclr_v))));
    // R4
    first_hold_chk: assert property (@(posedge clk_i) disable iff (!cold_rst_n_i)
        (!first_empty && fclr_v == '0) |=> (st_q.first == $past(st_q.first)));
    // R10
    warm_hold_chk: assert property (@(posedge clk_i) disable iff (!cold_rst_n_i)
        !warm_rst_n_i |=> $stable(st_q));
endmodule

// File: rtl/errlog_snapshot.sv
module errlog_snapshot #(
    parameter int ADDR_W = 40,
    parameter int CMD_W  = 4,
    parameter int DATA_W = 32,
    parameter int BE_W   = 4,
    parameter int REG_W  = 64,
    localparam int A_P0   = ADDR_W + CMD_W,
    localparam int A_P1   = A_P0 + 1,
    localparam int A_USED = A_P1 + 1,
    localparam int D_PAR  = DATA_W + BE_W,
    localparam int D_USED = D_PAR + 1
) (
    input  logic              clk_i,
    input  logic              cold_rst_n_i,
    input  logic              warm_rst_n_i,
    input  logic              capture_i,
    input  logic              frozen_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [CMD_W-1:0]  bus_cmd_i,
    input  logic              bus_dac_i,
    input  logic              bus_apar_i,
    input  logic              bus_apar2_i,
    input  logic [DATA_W-1:0] bus_data_i,
    input  logic [BE_W-1:0]   bus_be_i,
    input  logic              bus_dpar_i,
    input  logic              addr_wr_i,
    input  logic              data_wr_i,
    input  logic [A_USED-1:0] addr_wdata_i,
    input  logic [D_USED-1:0] data_wdata_i,
    output logic [REG_W-1:0]  addr_reg_o,
    output logic [REG_W-1:0]  data_reg_o
);
    typedef struct packed {
        logic [A_USED-1:0] addr;
        logic [D_USED-1:0] data;
    } snap_t;

    snap_t snap_d, snap_q;
    logic  wr_ok;

    assign wr_ok = warm_rst_n_i && !frozen_i;

    always_comb begin
        snap_d = snap_q;
        if (capture_i) begin
            snap_d.addr = {bus_dac_i & bus_apar2_i, bus_apar_i, bus_cmd_i, bus_addr_i};
            snap_d.data = {bus_dpar_i, bus_be_i, bus_data_i};
        end else begin
            if (addr_wr_i && wr_ok) snap_d.addr = addr_wdata_i;
            if (data_wr_i && wr_ok) snap_d.data = data_wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge cold_rst_n_i) begin
        if (!cold_rst_n_i) snap_q <= '0;
        else               snap_q <= snap_d;
    end

    generate
        if (REG_W > A_USED) begin : g_apad
            assign addr_reg_o = {{(REG_W-A_USED){1'b0}}, snap_q.addr};
        end else begin : g_anopad
            assign addr_reg_o = snap_q.addr[REG_W-1:0];
        end
        if (REG_W > D_USED) begin : g_dpad
            assign data_reg_o = {{(REG_W-D_USED){1'b0}}, snap_q.data};
        end else begin : g_dnopad
            assign data_reg_o = snap_q.data[REG_W-1:0];
        end
    endgenerate

    // R6
    snap_frozen_chk: assert property (@(posedge clk_i) disable iff (!cold_rst_n_i)
        frozen_i |=> $stable(snap_q));
    // R7
    single_cycle_p2_chk: assert property (@(posedge clk_i) disable iff (!cold_rst_n_i)
        (capture_i && !bus_dac_i) |=> (snap_q.addr[A_P1] == 1'b0));
    // R10
    snap_warm_chk: assert property (@(posedge clk_i) disable iff (!cold_rst_n_i)
        (!warm_rst_n_i && !capture_i) |=> $stable(snap_q));
endmodule

// File: rtl/err_capture_logger.sv
module err_capture_logger #(
    parameter int EVT_W  = 8,
    parameter int ADDR_W = 40,
    parameter int CMD_W  = 4,
    parameter int DATA_W = 32,
    parameter int BE_W   = 4,
    parameter int REG_W  = 64
) (
    input  logic              clk_i,
    input  logic              cold_rst_n_i,
    input  logic              warm_rst_n_i,
    input  logic [EVT_W-1:0]  err_evt_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [CMD_W-1:0]  bus_cmd_i,
    input  logic              bus_dac_i,
    input  logic              bus_apar_i,
    input  logic              bus_apar2_i,
    input  logic [DATA_W-1:0] bus_data_i,
    input  logic [BE_W-1:0]   bus_be_i,
    input  logic              bus_dpar_i,
    input  logic [1:0]        reg_sel_i,
    input  logic              reg_wr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    output logic              err_pending_o
);
    import errlog_pkg::*;

    localparam int A_USED = ADDR_W + CMD_W + 2;
    localparam int D_USED = DATA_W + BE_W + 1;

    errlog_sel_e      sel;
    logic [EVT_W-1:0] first_q, next_q, first_clr, next_clr;
    logic             new_first, frozen;
    logic             addr_wr, data_wr;
    logic [REG_W-1:0] addr_reg, data_reg;
    logic             unused_wbits;

    assign sel       = errlog_sel_e'(reg_sel_i);
    assign first_clr = (reg_wr_i && sel == SEL_FIRST) ? reg_wdata_i[EVT_W-1:0] : '0;
    assign next_clr  = (reg_wr_i && sel == SEL_NEXT)  ? reg_wdata_i[EVT_W-1:0] : '0;
    assign addr_wr   = reg_wr_i && sel == SEL_ADDR;
    assign data_wr   = reg_wr_i && sel == SEL_DATA;
    assign unused_wbits = ^reg_wdata_i[REG_W-1:A_USED];

    errlog_status #(.EVT_W(EVT_W)) u_status (
        .clk_i        (clk_i),
        .cold_rst_n_i (cold_rst_n_i),
        .warm_rst_n_i (warm_rst_n_i),
        .evt_i        (err_evt_i),
        .first_clr_i  (first_clr),
        .next_clr_i   (next_clr),
        .first_o      (first_q),
        .next_o       (next_q),
        .new_first_o  (new_first),
        .frozen_o     (frozen)
    );

    errlog_snapshot #(
        .ADDR_W (ADDR_W),
        .CMD_W  (CMD_W),
        .DATA_W (DATA_W),
        .BE_W   (BE_W),
        .REG_W  (REG_W)
    ) u_snapshot (
        .clk_i        (clk_i),
        .cold_rst_n_i (cold_rst_n_i),
        .warm_rst_n_i (warm_rst_n_i),
        .capture_i    (new_first),
        .frozen_i     (frozen),
        .bus_addr_i   (bus_addr_i),
        .bus_cmd_i    (bus_cmd_i),
        .bus_dac_i    (bus_dac_i),
        .bus_apar_i   (bus_apar_i),
        .bus_apar2_i  (bus_apar2_i),
        .bus_data_i   (bus_data_i),
        .bus_be_i     (bus_be_i),
        .bus_dpar_i   (bus_dpar_i),
        .addr_wr_i    (addr_wr),
        .data_wr_i    (data_wr),
        .addr_wdata_i (reg_wdata_i[A_USED-1:0]),
        .data_wdata_i (reg_wdata_i[D_USED-1:0]),
        .addr_reg_o   (addr_reg),
        .data_reg_o   (data_reg)
    );

    always_comb begin
        reg_rdata_o = '0;
        unique case (sel)
            SEL_FIRST: reg_rdata_o[EVT_W-1:0] = first_q;
            SEL_NEXT:  reg_rdata_o[EVT_W-1:0] = next_q;
            SEL_ADDR:  reg_rdata_o = addr_reg;
            SEL_DATA:  reg_rdata_o = data_reg;
            default:   reg_rdata_o = '0;
        endcase
    end

    assign err_pending_o = (first_q != '0) || (next_q != '0);

    // R11
    pending_rise_chk: assert property (@(posedge clk_i) disable iff (!cold_rst_n_i)
        $rose(err_pending_o) |-> $past(warm_rst_n_i && err_evt_i != '0));
    // R4
    pending_fall_chk: assert property (@(posedge clk_i) disable iff (!cold_rst_n_i)
        $fell(err_pending_o) |-> $past(reg_wr_i && warm_rst_n_i));
endmodule

// File: tb/err_capture_logger_tb.sv
module err_capture_logger_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        cold_rst_n = 1'b0;
    logic        warm_rst_n = 1'b1;
    logic [7:0]  evt = '0;
    logic [39:0] baddr = '0;
    logic [3:0]  bcmd = '0;
    logic        bdac = 1'b0, bap = 1'b0, bap2 = 1'b0;
    logic [31:0] bdata = '0;
    logic [3:0]  bbe = '0;
    logic        bdp = 1'b0;
    logic [1:0]  sel = '0;
    logic        wr = 1'b0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic        pending;
    int          n_chk = 0;
    int          n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    err_capture_logger u_dut (
        .clk_i(clk), .cold_rst_n_i(cold_rst_n), .warm_rst_n_i(warm_rst_n),
        .err_evt_i(evt), .bus_addr_i(baddr), .bus_cmd_i(bcmd), .bus_dac_i(bdac),
        .bus_apar_i(bap), .bus_apar2_i(bap2), .bus_data_i(bdata), .bus_be_i(bbe),
        .bus_dpar_i(bdp), .reg_sel_i(sel), .reg_wr_i(wr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .err_pending_o(pending)
    );

    function automatic logic [63:0] exp_addr(input logic [39:0] a, input logic [3:0] c,
                                              input logic p, input logic p2, input logic dac);
        return {18'b0, dac & p2, p, c, a};
    endfunction

    function automatic logic [63:0] exp_data(input logic [31:0] d, input logic [3:0] be,
                                              input logic p);
        return {27'b0, p, be, d};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] s, input logic [63:0] exp, input string req);
        sel = s;
        #1;
        chk(req, rdata, exp);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        evt = '0;
        wr  = 1'b0;
    endtask

    task automatic drive(input logic [7:0] e, input logic w, input logic [1:0] s,
                         input logic [63:0] d);
        @(negedge clk);
        evt = e; wr = w; sel = s; wdata = d;
        tick();
    endtask

    task automatic set_bus(input logic [39:0] a, input logic [3:0] c, input logic dac,
                           input logic p, input logic p2, input logic [31:0] d,
                           input logic [3:0] be, input logic dp);
        baddr = a; bcmd = c; bdac = dac; bap = p; bap2 = p2;
        bdata = d; bbe = be; bdp = dp;
    endtask

    task automatic t_reset();
        rd(2'd0, 64'h0, "R1 first after reset");
        rd(2'd1, 64'h0, "R1 next after reset");
        rd(2'd2, 64'h0, "R12 addr sel after reset");
        rd(2'd3, 64'h0, "R12 data sel after reset");
        chk("R1 pending after reset", {63'b0, pending}, 64'h0);
    endtask

    task automatic t_first_capture();
        set_bus(40'h12_3456_789A, 4'hB, 1'b0, 1'b1, 1'b1, 32'hDEAD_BEEF, 4'h5, 1'b1);
        drive(8'h05, 1'b0, 2'd0, 64'h0);
        rd(2'd0, 64'h05, "R2 first captured");
        rd(2'd1, 64'h00, "R3 next not duplicated");
        rd(2'd2, exp_addr(40'h12_3456_789A, 4'hB, 1'b1, 1'b1, 1'b0), "R6 R7 addr snapshot single cycle");
        rd(2'd3, exp_data(32'hDEAD_BEEF, 4'h5, 1'b1), "R8 data snapshot");
        chk("R11 pending set", {63'b0, pending}, 64'h1);
    endtask

    task automatic t_next_accum();
        set_bus(40'h00_0000_0F0F, 4'h2, 1'b1, 1'b0, 1'b1, 32'h1111_2222, 4'hA, 1'b0);
        drive(8'h06, 1'b0, 2'd0, 64'h0);
        drive(8'h81, 1'b0, 2'd0, 64'h0);
        rd(2'd1, 64'h87, "R3 next accumulates");
        rd(2'd0, 64'h05, "R3 first unchanged");
        rd(2'd2, exp_addr(40'h12_3456_789A, 4'hB, 1'b1, 1'b1, 1'b0), "R6 addr frozen");
        rd(2'd3, exp_data(32'hDEAD_BEEF, 4'h5, 1'b1), "R8 data frozen");
    endtask

    task automatic t_frozen_write();
        drive(8'h00, 1'b1, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF);
        drive(8'h00, 1'b1, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(2'd2, exp_addr(40'h12_3456_789A, 4'hB, 1'b1, 1'b1, 1'b0), "R9 addr write blocked");
        rd(2'd3, exp_data(32'hDEAD_BEEF, 4'h5, 1'b1), "R9 data write blocked");
    endtask

    task automatic t_w1c();
        drive(8'h00, 1'b1, 2'd1, 64'h04);
        rd(2'd1, 64'h83, "R4 next w1c");
        drive(8'h00, 1'b1, 2'd0, 64'h01);
        rd(2'd0, 64'h04, "R4 first w1c");
    endtask

    task automatic t_collide();
        drive(8'h80, 1'b1, 2'd1, 64'h80);
        rd(2'd1, 64'h83, "R5 set wins over clear");
        drive(8'h10, 1'b1, 2'd0, 64'h04);
        rd(2'd0, 64'h00, "R5 first emptied");
        rd(2'd1, 64'h93, "R5 event into next");
        chk("R11 pending with next only", {63'b0, pending}, 64'h1);
        drive(8'h00, 1'b1, 2'd1, 64'hFF);
        chk("R11 pending cleared", {63'b0, pending}, 64'h0);
    endtask

    task automatic t_sw_snapshot();
        drive(8'h00, 1'b1, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(2'd2, 64'h0000_3FFF_FFFF_FFFF, "R9 R7 addr write masked");
        drive(8'h00, 1'b1, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(2'd3, 64'h0000_001F_FFFF_FFFF, "R9 R8 data write masked");
        drive(8'h00, 1'b1, 2'd2, 64'h0);
        rd(2'd2, 64'h0, "R9 addr write zero");
    endtask

    task automatic t_rearm_dac();
        set_bus(40'hA5_0000_0001, 4'h3, 1'b1, 1'b0, 1'b1, 32'h0102_0304, 4'hF, 1'b0);
        drive(8'h40, 1'b1, 2'd2, 64'h1234);
        rd(2'd0, 64'h40, "R2 new first after clear");
        rd(2'd2, exp_addr(40'hA5_0000_0001, 4'h3, 1'b0, 1'b1, 1'b1), "R9 R7 capture beats write dual cycle");
        rd(2'd3, exp_data(32'h0102_0304, 4'hF, 1'b0), "R9 data re-snapshot");
    endtask

    task automatic t_warm();
        @(negedge clk);
        warm_rst_n = 1'b0;
        drive(8'hFF, 1'b1, 2'd0, 64'hFF);
        drive(8'hFF, 1'b1, 2'd1, 64'hFF);
        @(negedge clk);
        warm_rst_n = 1'b1;
        rd(2'd0, 64'h40, "R10 first kept");
        rd(2'd1, 64'h00, "R10 next kept");
        rd(2'd2, exp_addr(40'hA5_0000_0001, 4'h3, 1'b0, 1'b1, 1'b1), "R10 addr kept");
    endtask

    task automatic t_cold();
        @(negedge clk);
        cold_rst_n = 1'b0;
        #1;
        rd(2'd0, 64'h0, "R1 first cold cleared");
        rd(2'd3, 64'h0, "R1 data cold cleared");
        chk("R1 pending cold cleared", {63'b0, pending}, 64'h0);
        @(negedge clk);
        cold_rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        cold_rst_n = 1'b1;
        t_reset();
        t_first_capture();
        t_next_accum();
        t_frozen_write();
        t_w1c();
        t_collide();
        t_sw_snapshot();
        t_rearm_dac();
        t_warm();
        t_cold();
        repeat (2) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule